// File: doc/BRIEF.md
# Byte-Addressed Data Memory Controller

This block is a data memory for a load/store datapath. The address is 32 bits and counts bytes. Both data buses are 32 bits wide. The storage is an array of words whose depth is a parameter. An enable input gates every operation. When enable is high, a 2-bit control code chooses the operation: a word read, a single-byte store, a halfword store or a full-word store.

Words are big-endian, so the byte at offset 0 within a word sits in bits [31:24]. A sub-word store changes only the byte lanes it addresses. Halfword accesses must be 2-byte aligned and word accesses must be 4-byte aligned. A misaligned access raises an alignment-error flag and leaves the storage untouched. The storage is kept as four byte-wide lanes, each with its own write enable, so that an FPGA block RAM with byte enables can be inferred. Read data and the error flag are registered: a read issued in one cycle is visible after the next rising edge. Only the address bits needed for the configured depth are decoded.

Top module: `dmem_ctrl`

## Requirements
- R1: A synchronous active-high reset clears `rdata` to 0 and `align_err` to 0.
- R2: With `en`=1 and `mc`=11 at a 4-byte-aligned address, the whole of `wdata` is stored at the rising edge. A later `mc`=00 read of that address presents the word on `rdata` after the next rising edge.
- R3: With `en`=1 and `mc`=01, `wdata[7:0]` is stored into the byte at `addr`. Offset 0 maps to bits [31:24], offset 1 to [23:16], offset 2 to [15:8] and offset 3 to [7:0]. The other three bytes of the word are unchanged.
- R4: With `en`=1 and `mc`=10 at an even address, `wdata[15:0]` is stored with its high byte first. `addr[1]`=0 selects bits [31:16] and `addr[1]`=1 selects bits [15:0]. The other half of the word is unchanged.
- R5: An enabled access is misaligned when `mc`=10 and `addr[0]`=1, or when `mc` is 00 or 11 and `addr[1:0]` is not 00. Such an access sets `align_err` to 1 after the next rising edge. It changes no stored byte and does not change `rdata`.
- R6: After any cycle without a misaligned enabled access, `align_err` is 0 after the next rising edge. This covers byte stores at any offset and cycles with `en` low.
- R7: With `en`=0 nothing is stored, whatever `mc`, `addr` and `wdata` are, and `rdata` holds.
- R8: Address bits above the word index are ignored. Two addresses that differ only by a multiple of 4*DEPTH reach the same word.
- R9: `rdata` changes only after an enabled, aligned `mc`=00 read. Stores leave it holding its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Operation enable |
| mc | input | 2 | Control: 00 word read, 01 byte store, 10 halfword store, 11 word store |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Store data |
| rdata | output | 32 | Registered word read data |
| align_err | output | 1 | Registered misalignment flag |

## Verification
The bench stores a byte at every lane offset and a halfword into each half, then reads the word back. A design that mirrored the byte order or wrote more lanes than addressed would return corrupted neighbouring bytes. Misaligned halfword stores, word stores and word reads are each followed by a read of the target. This catches a design that let a misaligned access reach the storage or move `rdata`, and the bench also checks that the flag clears on the next clean cycle. A store with enable low, and accesses through high aliased addresses, expose a design that ignores `en` or decodes too many or too few address bits.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [1:0] {
    MC_RD_WORD = 2'b00,
    MC_WR_BYTE = 2'b01,
    MC_WR_HALF = 2'b10,
    MC_WR_WORD = 2'b11
  } mc_e;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                en,
  input  logic [1:0]          mc,
  input  logic [IDX_W+1:0]    addr_lo,
  input  logic [DATA_W-1:0]   wdata,
  output logic [IDX_W-1:0]    idx,
  output logic [LANES-1:0]    lane_we,
  output logic [DATA_W-1:0]   lane_wd,
  output logic                rd_en,
  output logic                err_now
);
  logic [1:0] off;
  logic       bad;

  always_comb begin
    off     = addr_lo[1:0];
    idx     = addr_lo[IDX_W+1:2];
    bad     = 1'b0;
    lane_we = '0;
    lane_wd = '0;
    rd_en   = 1'b0;
    case (mc_e'(mc))
      MC_RD_WORD, MC_WR_WORD: bad = (off != 2'b00);
      MC_WR_HALF:             bad = off[0];
      default:                bad = 1'b0;
    endcase
    if (en && !bad) begin
      case (mc_e'(mc))
        MC_RD_WORD: rd_en = 1'b1;
        MC_WR_BYTE: begin
          lane_we[2'd3 - off] = 1'b1;
          lane_wd = {LANES{wdata[7:0]}};
        end
        MC_WR_HALF: begin
          lane_we = off[1] ? 4'b0011 : 4'b1100;
          lane_wd = {2{wdata[15:0]}};
        end
        default: begin
          lane_we = '1;
          lane_wd = wdata;
        end
      endcase
    end
    err_now = en && bad;
  end
endmodule

// File: rtl/dmem_lane.sv
module dmem_lane #(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             re,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wd,
  output logic [7:0]       q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[idx];
  end
endmodule

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmem_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [1:0]  mc,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        align_err
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0]  idx;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] lane_wd;
  logic              rd_en;
  logic              err_now;
  logic              unused_hi;

  assign unused_hi = ^addr[31:IDX_W+2];

  dmem_decode #(.IDX_W(IDX_W)) u_dec (
    .en      (en),
    .mc      (mc),
    .addr_lo (addr[IDX_W+1:0]),
    .wdata   (wdata),
    .idx     (idx),
    .lane_we (lane_we),
    .lane_wd (lane_wd),
    .rd_en   (rd_en),
    .err_now (err_now)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dmem_lane #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_lane (
      .clk (clk),
      .rst (rst),
      .we  (lane_we[l]),
      .re  (rd_en),
      .idx (idx),
      .wd  (lane_wd[8*l +: 8]),
      .q   (rdata[8*l +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) align_err <= 1'b0;
    else     align_err <= err_now;
  end
endmodule

// File: rtl/dmem_ctrl_chk.sv
module dmem_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic [1:0]  mc,
  input logic [31:0] addr,
  input logic [31:0] rdata,
  input logic        align_err
);
  logic misaligned;
  logic good_read;

  always_comb begin
    misaligned = en && ((mc == 2'b10 && addr[0]) ||
                        ((mc == 2'b00 || mc == 2'b11) && addr[1:0] != 2'b00));
    good_read  = en && mc == 2'b00 && addr[1:0] == 2'b00;
  end

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rdata == 32'h0 && !align_err));

  p_err_set_r5: assert property (@(posedge clk) disable iff (rst)
    misaligned |=> align_err);

  p_err_clear_r6: assert property (@(posedge clk) disable iff (rst)
    !misaligned |=> !align_err);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !good_read |=> $stable(rdata));

  p_disabled_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(rdata) && !align_err));
endmodule

bind dmem_ctrl dmem_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .mc        (mc),
  .addr      (addr),
  .rdata     (rdata),
  .align_err (align_err)
);

// File: tb/dmem_ctrl_tb.sv
`timescale 1ns/100ps
module dmem_ctrl_tb;
  localparam int DEPTH = 64;
  localparam int BYTES = DEPTH * 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  mc = 2'b00;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        align_err;

  always #2.5 clk = ~clk;

  dmem_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .en(en), .mc(mc), .addr(addr),
    .wdata(wdata), .rdata(rdata), .align_err(align_err)
  );

  logic [7:0]  mdl [BYTES];
  logic [31:0] exp_rd = '0;
  logic [32:0] q_exp [$];
  string       q_tag [$];
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  function automatic int bidx(input logic [31:0] a);
    return int'(a % BYTES);
  endfunction

  task automatic op(input logic e, input logic [1:0] c, input logic [31:0] a,
                    input logic [31:0] d, input string tag);
    logic bad;
    logic er;
    int   b;
    @(negedge clk);
    en = e; mc = c; addr = a; wdata = d;
    bad = (c == 2'b10 && a[0]) || ((c == 2'b00 || c == 2'b11) && a[1:0] != 2'b00);
    er  = e && bad;
    b   = bidx(a);
    if (e && !bad) begin
      case (c)
        2'b00: begin
          b = bidx({a[31:2], 2'b00});
          exp_rd = {mdl[b], mdl[b+1], mdl[b+2], mdl[b+3]};
        end
        2'b01: mdl[b] = d[7:0];
        2'b10: begin mdl[b] = d[15:8]; mdl[b+1] = d[7:0]; end
        default: begin
          mdl[b] = d[31:24]; mdl[b+1] = d[23:16];
          mdl[b+2] = d[15:8]; mdl[b+3] = d[7:0];
        end
      endcase
    end
    q_exp.push_back({er, exp_rd});
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    logic [32:0] ex;
    string       tg;
    #1;
    if (!rst && q_exp.size() > 0) begin
      ex = q_exp.pop_front();
      tg = q_tag.pop_front();
      checks++;
      if (rdata !== ex[31:0] || align_err !== ex[32]) begin
        fails++;
        $display("FAIL %s: rdata=%h align_err=%b expected rdata=%h align_err=%b",
                 tg, rdata, align_err, ex[31:0], ex[32]);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    op(0, 2'b00, 32'h0, 32'h0, "R1 reset state");
    // R2 aligned word store and read
    op(1, 2'b11, 32'h10, 32'h11223344, "R2 word store");
    op(1, 2'b00, 32'h10, 32'h0, "R2 word read");
    // R3 byte lanes, big-endian
    op(1, 2'b01, 32'h11, 32'hFFFFFFAA, "R3 byte off1");
    op(1, 2'b00, 32'h10, 32'h0, "R3 read after off1");
    op(1, 2'b01, 32'h13, 32'h00000055, "R3 byte off3");
    op(1, 2'b01, 32'h10, 32'h000000C3, "R3 byte off0");
    op(1, 2'b01, 32'h12, 32'h0000007E, "R3 byte off2");
    op(1, 2'b00, 32'h10, 32'h0, "R3 read all lanes");
    // R4 halfwords
    op(1, 2'b11, 32'h20, 32'h01020304, "R4 word preset");
    op(1, 2'b10, 32'h22, 32'h1234BEEF, "R4 low half");
    op(1, 2'b00, 32'h20, 32'h0, "R4 read low half");
    op(1, 2'b10, 32'h20, 32'h5678CAFE, "R4 high half");
    op(1, 2'b00, 32'h20, 32'h0, "R4 read high half");
    // R5 misaligned accesses
    op(1, 2'b10, 32'h21, 32'hFFFFFFFF, "R5 odd halfword");
    op(1, 2'b11, 32'h22, 32'hFFFFFFFF, "R5 misaligned word store");
    op(1, 2'b11, 32'h13, 32'h0, "R5 misaligned word store off3");
    op(1, 2'b00, 32'h21, 32'h0, "R5 misaligned read holds rdata");
    op(1, 2'b01, 32'h23, 32'h00000099, "R6 byte store clears flag");
    op(1, 2'b00, 32'h20, 32'h0, "R5 target unchanged");
    op(1, 2'b00, 32'h12, 32'h0, "R5 misaligned read");
    op(0, 2'b00, 32'h12, 32'h0, "R6 idle clears flag");
    // R7 disabled store ignored
    op(0, 2'b11, 32'h10, 32'hDEADBEEF, "R7 disabled store");
    op(0, 2'b00, 32'h20, 32'h0, "R7 disabled read holds");
    op(1, 2'b00, 32'h10, 32'h0, "R7 word unchanged");
    // R8 aliasing
    op(1, 2'b11, 32'h10 + BYTES, 32'h0BADF00D, "R8 aliased store");
    op(1, 2'b00, 32'h10, 32'h0, "R8 read base");
    op(1, 2'b00, 32'hFFFF0010, 32'h0, "R8 read high alias");
    op(1, 2'b01, 32'h8000_0000 + 32'h13, 32'h0000_0011, "R8 aliased byte");
    op(1, 2'b00, 32'h10, 32'h0, "R8 read after aliased byte");
    // R9 stores leave rdata and a sweep of words
    for (int i = 0; i < 16; i++)
      op(1, 2'b11, 32'h40 + 4 * i, 32'hA5000000 ^ (i * 32'h01010101), "R9 store holds rdata");
    for (int i = 0; i < 16; i++)
      op(1, 2'b00, 32'h40 + 4 * i, 32'h0, "R2 sweep read");
    op(0, 2'b00, 32'h0, 32'h0, "R6 final idle");
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule